// File: doc/BRIEF.md
# Processor bus region decoder

This block stands between the two request ports of a 32-bit processor and the three places a request can land: a dual-ported internal RAM, an external-memory bus master and a peripheral bus master. The instruction side is read-only. The data side reads and writes. For each pending request, the block looks at the top byte of the byte address, picks one target and forwards the word address in the width that target needs. It returns that target's acknowledge and read data to the side that asked, in the same cycle.

The internal RAM has one port for each side, so the two sides never compete for it. The external-memory master and the peripheral master are each shared by both sides. A small arbiter in front of each one gives the data side priority. Once a side holds a shared target, it keeps it until that target acknowledges.

The block also covers the processor's first fetch after reset. That fetch is aimed at the topmost word of the address space. The block answers it on its own with a fixed no-operation word, so the program counter wraps and execution starts at address zero. A data access to the same address is not intercepted.

Top module: `bus_region_router`

## Requirements
- R1: A request whose address has top byte 00h goes to that side's RAM port (`ram_i_en` / `ram_d_en`). The RAM word address is byte address bits [23:2].
- R2: A request whose top byte is 01h to FEh goes to the external-memory master. `ext_addr` carries byte address bits [31:2].
- R3: A request whose top byte is FFh goes to the peripheral master. `io_addr` carries byte address bits [23:0].
- R4: An instruction fetch from FFFF_FFFCh is acknowledged in the same cycle with read data 6000_0000h. No target is selected for it.
- R5: A data access to FFFF_FFFCh is routed to the peripheral master like any other peripheral address, with `io_addr` = FF_FFFCh.
- R6: With no request pending, no target select is asserted. Every address and write-data output not in use reads zero.
- R7: When both sides request the same shared target in one cycle and that target is free, the data side is granted first. The instruction side gets no acknowledge until the data side has been acknowledged.
- R8: A side that holds a shared target keeps it until the target acknowledges, even if the other side requests it meanwhile.
- R9: A target's acknowledge and read data reach the granted side in the same cycle. The other side's acknowledge stays low and its read data reads zero. The two sides may be served by different targets in the same cycle.
- R10: Write enable and write data are forwarded only for data-side requests. An instruction-side request never asserts `ext_we` or `io_we`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ifetch_req | input | 1 | Instruction fetch request |
| ifetch_addr | input | 32 | Instruction byte address |
| ifetch_ack | output | 1 | Instruction fetch acknowledge |
| ifetch_rdata | output | 32 | Instruction word returned |
| dat_req | input | 1 | Data access request |
| dat_we | input | 1 | Data access is a write |
| dat_addr | input | 32 | Data byte address |
| dat_wdata | input | 32 | Data write word |
| dat_ack | output | 1 | Data access acknowledge |
| dat_rdata | output | 32 | Data read word |
| ram_i_en | output | 1 | Instruction-side RAM port enable |
| ram_i_addr | output | 22 | Instruction-side RAM word address |
| ram_i_ack | input | 1 | Instruction-side RAM acknowledge |
| ram_i_rdata | input | 32 | Instruction-side RAM read word |
| ram_d_en | output | 1 | Data-side RAM port enable |
| ram_d_we | output | 1 | Data-side RAM write enable |
| ram_d_addr | output | 22 | Data-side RAM word address |
| ram_d_wdata | output | 32 | Data-side RAM write word |
| ram_d_ack | input | 1 | Data-side RAM acknowledge |
| ram_d_rdata | input | 32 | Data-side RAM read word |
| ext_sel | output | 1 | External-memory master select |
| ext_we | output | 1 | External-memory write enable |
| ext_addr | output | 30 | External-memory word address |
| ext_wdata | output | 32 | External-memory write word |
| ext_ack | input | 1 | External-memory acknowledge |
| ext_rdata | input | 32 | External-memory read word |
| io_sel | output | 1 | Peripheral master select |
| io_we | output | 1 | Peripheral write enable |
| io_addr | output | 24 | Peripheral byte address |
| io_wdata | output | 32 | Peripheral write word |
| io_ack | input | 1 | Peripheral acknowledge |
| io_rdata | input | 32 | Peripheral read word |

## Verification
The only state in this block is the owner register of each shared-target arbiter. A stale or wrong owner shows up at the ports in the very next cycle. The symptoms are a select carrying the other side's address, an acknowledge handed to a side that was not granted, or a held request being dropped. The bench therefore runs multi-cycle contention sequences and checks the ports every cycle: simultaneous requests, a request arriving while the other side holds the target, and the release that follows an acknowledge. Decode errors are combinational and visible in the same cycle. Region boundaries and the reset-vector address are probed from both sides.

// File: rtl/brr_pkg.sv
package brr_pkg;
    typedef enum logic [1:0] {
        RGN_RAM = 2'd0,
        RGN_EXT = 2'd1,
        RGN_IO  = 2'd2,
        RGN_NOP = 2'd3
    } rgn_e;

    typedef enum logic [1:0] {
        OWN_NONE = 2'd0,
        OWN_INS  = 2'd1,
        OWN_DAT  = 2'd2
    } own_e;

    typedef struct packed {
        own_e owner;
    } arb_st_t;

    localparam logic [31:0] BOOT_ADDR = 32'hFFFF_FFFC;
    localparam logic [31:0] NOP_WORD  = 32'h6000_0000;
    localparam logic [7:0]  RAM_TOP   = 8'h00;
    localparam logic [7:0]  IO_TOP    = 8'hFF;
endpackage

// File: rtl/brr_region_decode.sv
module brr_region_decode
    import brr_pkg::*;
#(
    parameter bit IS_FETCH = 1'b0
) (
    input  logic [31:0] addr,
    output rgn_e        rgn
);
    logic at_boot;
    logic [7:0] top_byte;

    assign top_byte = addr[31:24];
    assign at_boot  = (addr == BOOT_ADDR);

    generate
        if (IS_FETCH) begin : g_fetch
            always_comb begin
                if (at_boot)                 rgn = RGN_NOP;
                else if (top_byte == RAM_TOP) rgn = RGN_RAM;
                else if (top_byte == IO_TOP)  rgn = RGN_IO;
                else                          rgn = RGN_EXT;
            end
        end else begin : g_data
            logic unused_boot;
            assign unused_boot = at_boot;
            always_comb begin
                if (top_byte == RAM_TOP)     rgn = RGN_RAM;
                else if (top_byte == IO_TOP) rgn = RGN_IO;
                else                         rgn = RGN_EXT;
            end
        end
    endgenerate
endmodule

// File: rtl/brr_shared_arb.sv
module brr_shared_arb
    import brr_pkg::*;
#(
    parameter int AW = 30,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          i_req,
    input  logic [AW-1:0] i_addr,
    input  logic          d_req,
    input  logic          d_we,
    input  logic [AW-1:0] d_addr,
    input  logic [DW-1:0] d_wdata,
    output logic          t_sel,
    output logic          t_we,
    output logic [AW-1:0] t_addr,
    output logic [DW-1:0] t_wdata,
    input  logic          t_ack,
    input  logic [DW-1:0] t_rdata,
    output logic          i_ack,
    output logic          d_ack,
    output logic [DW-1:0] i_rdata,
    output logic [DW-1:0] d_rdata
);
    arb_st_t st_d, st_q;
    logic    grant_i, grant_d, owner_live;

    always_comb begin
        st_d       = st_q;
        grant_i    = 1'b0;
        grant_d    = 1'b0;
        owner_live = ((st_q.owner == OWN_INS) && i_req) ||
                     ((st_q.owner == OWN_DAT) && d_req);
        if (owner_live) begin
            grant_i = (st_q.owner == OWN_INS);
            grant_d = (st_q.owner == OWN_DAT);
        end else if (d_req) begin
            grant_d = 1'b1;
        end else if (i_req) begin
            grant_i = 1'b1;
        end

        if (t_ack)        st_d.owner = OWN_NONE;
        else if (grant_d) st_d.owner = OWN_DAT;
        else if (grant_i) st_d.owner = OWN_INS;
        else              st_d.owner = OWN_NONE;

        t_sel   = grant_i | grant_d;
        t_we    = grant_d & d_we;
        t_addr  = grant_d ? d_addr : (grant_i ? i_addr : '0);
        t_wdata = grant_d ? d_wdata : '0;
        i_ack   = grant_i & t_ack;
        d_ack   = grant_d & t_ack;
        i_rdata = i_ack ? t_rdata : '0;
        d_rdata = d_ack ? t_rdata : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{owner: OWN_NONE};
        else        st_q <= st_d;
    end

    assert_single_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({i_ack, d_ack}));

    assert_data_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.owner == OWN_NONE && i_req && d_req) |-> (t_sel && !i_ack && t_addr == d_addr));

    assert_ins_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.owner == OWN_INS && i_req) |-> (!d_ack && t_sel && !t_we));

    assert_dat_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.owner == OWN_DAT && d_req) |-> (!i_ack && t_sel));

    assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (t_sel && t_ack) |=> (st_q.owner == OWN_NONE));
endmodule

// File: rtl/bus_region_router.sv
module bus_region_router
    import brr_pkg::*;
#(
    parameter int DW     = 32,
    parameter int RAM_AW = 22,
    parameter int EXT_AW = 30,
    parameter int IO_AW  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ifetch_req,
    input  logic [31:0]       ifetch_addr,
    output logic              ifetch_ack,
    output logic [DW-1:0]     ifetch_rdata,
    input  logic              dat_req,
    input  logic              dat_we,
    input  logic [31:0]       dat_addr,
    input  logic [DW-1:0]     dat_wdata,
    output logic              dat_ack,
    output logic [DW-1:0]     dat_rdata,
    output logic              ram_i_en,
    output logic [RAM_AW-1:0] ram_i_addr,
    input  logic              ram_i_ack,
    input  logic [DW-1:0]     ram_i_rdata,
    output logic              ram_d_en,
    output logic              ram_d_we,
    output logic [RAM_AW-1:0] ram_d_addr,
    output logic [DW-1:0]     ram_d_wdata,
    input  logic              ram_d_ack,
    input  logic [DW-1:0]     ram_d_rdata,
    output logic              ext_sel,
    output logic              ext_we,
    output logic [EXT_AW-1:0] ext_addr,
    output logic [DW-1:0]     ext_wdata,
    input  logic              ext_ack,
    input  logic [DW-1:0]     ext_rdata,
    output logic              io_sel,
    output logic              io_we,
    output logic [IO_AW-1:0]  io_addr,
    output logic [DW-1:0]     io_wdata,
    input  logic              io_ack,
    input  logic [DW-1:0]     io_rdata
);
    localparam int WORD_LSB = 2;
    localparam int RAM_MSB  = RAM_AW + WORD_LSB - 1;

    rgn_e i_rgn, d_rgn;
    logic i_nop, i_ram, i_ext, i_io, d_ram, d_ext, d_io;
    logic ext_i_ack, ext_d_ack, io_i_ack, io_d_ack;
    logic [DW-1:0] ext_i_rdata, ext_d_rdata, io_i_rdata, io_d_rdata;

    brr_region_decode #(.IS_FETCH(1'b1)) u_dec_ins (.addr(ifetch_addr), .rgn(i_rgn));
    brr_region_decode #(.IS_FETCH(1'b0)) u_dec_dat (.addr(dat_addr),    .rgn(d_rgn));

    always_comb begin
        i_nop = ifetch_req && (i_rgn == RGN_NOP);
        i_ram = ifetch_req && (i_rgn == RGN_RAM);
        i_ext = ifetch_req && (i_rgn == RGN_EXT);
        i_io  = ifetch_req && (i_rgn == RGN_IO);
        d_ram = dat_req && (d_rgn == RGN_RAM);
        d_ext = dat_req && (d_rgn == RGN_EXT);
        d_io  = dat_req && (d_rgn == RGN_IO);
    end

    always_comb begin
        ram_i_en    = i_ram;
        ram_i_addr  = i_ram ? ifetch_addr[RAM_MSB:WORD_LSB] : '0;
        ram_d_en    = d_ram;
        ram_d_we    = d_ram & dat_we;
        ram_d_addr  = d_ram ? dat_addr[RAM_MSB:WORD_LSB] : '0;
        ram_d_wdata = d_ram ? dat_wdata : '0;
    end

    brr_shared_arb #(.AW(EXT_AW), .DW(DW)) u_arb_ext (
        .clk     (clk),
        .rst_n   (rst_n),
        .i_req   (i_ext),
        .i_addr  (ifetch_addr[31:WORD_LSB]),
        .d_req   (d_ext),
        .d_we    (dat_we),
        .d_addr  (dat_addr[31:WORD_LSB]),
        .d_wdata (dat_wdata),
        .t_sel   (ext_sel),
        .t_we    (ext_we),
        .t_addr  (ext_addr),
        .t_wdata (ext_wdata),
        .t_ack   (ext_ack),
        .t_rdata (ext_rdata),
        .i_ack   (ext_i_ack),
        .d_ack   (ext_d_ack),
        .i_rdata (ext_i_rdata),
        .d_rdata (ext_d_rdata)
    );

    brr_shared_arb #(.AW(IO_AW), .DW(DW)) u_arb_io (
        .clk     (clk),
        .rst_n   (rst_n),
        .i_req   (i_io),
        .i_addr  (ifetch_addr[IO_AW-1:0]),
        .d_req   (d_io),
        .d_we    (dat_we),
        .d_addr  (dat_addr[IO_AW-1:0]),
        .d_wdata (dat_wdata),
        .t_sel   (io_sel),
        .t_we    (io_we),
        .t_addr  (io_addr),
        .t_wdata (io_wdata),
        .t_ack   (io_ack),
        .t_rdata (io_rdata),
        .i_ack   (io_i_ack),
        .d_ack   (io_d_ack),
        .i_rdata (io_i_rdata),
        .d_rdata (io_d_rdata)
    );

    always_comb begin
        ifetch_ack = i_nop | (i_ram & ram_i_ack) | ext_i_ack | io_i_ack;
        if (i_nop)                  ifetch_rdata = NOP_WORD;
        else if (i_ram & ram_i_ack) ifetch_rdata = ram_i_rdata;
        else                        ifetch_rdata = ext_i_rdata | io_i_rdata;

        dat_ack = (d_ram & ram_d_ack) | ext_d_ack | io_d_ack;
        if (d_ram & ram_d_ack) dat_rdata = ram_d_rdata;
        else                   dat_rdata = ext_d_rdata | io_d_rdata;
    end

    assert_boot_nop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ifetch_req && ifetch_addr == BOOT_ADDR) |->
        (ifetch_ack && ifetch_rdata == NOP_WORD && !ram_i_en));

    assert_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ifetch_req && !dat_req) |->
        (!ram_i_en && !ram_d_en && !ext_sel && !io_sel && !ifetch_ack && !dat_ack));

    assert_boot_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_req && dat_addr == BOOT_ADDR && !ifetch_req) |->
        (io_sel && io_addr == dat_addr[IO_AW-1:0] && !ram_d_en));

    assert_ins_no_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!dat_req) |-> (!ext_we && !io_we && !ram_d_we));

    assert_ram_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_req && dat_addr[31:24] == RAM_TOP) |-> (ram_d_en && !ext_d_ack && !io_d_ack));
endmodule

// File: tb/test_bus_region_router.sv
`timescale 1ns/1ps
module test_bus_region_router;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ifetch_req = 0, dat_req = 0, dat_we = 0;
    logic [31:0] ifetch_addr = 0, dat_addr = 0, dat_wdata = 0;
    logic        ram_i_ack = 1'b1, ram_d_ack = 1'b1, ext_ack = 0, io_ack = 0;
    logic [31:0] ram_i_rdata = 32'hA1A1_A1A1, ram_d_rdata = 32'hD1D1_D1D1;
    logic [31:0] ext_rdata = 32'hE0E0_E0E0, io_rdata = 32'hC0C0_C0C0;
    logic        ifetch_ack, dat_ack, ram_i_en, ram_d_en, ram_d_we;
    logic        ext_sel, ext_we, io_sel, io_we;
    logic [31:0] ifetch_rdata, dat_rdata, ram_d_wdata, ext_wdata, io_wdata;
    logic [21:0] ram_i_addr, ram_d_addr;
    logic [29:0] ext_addr;
    logic [23:0] io_addr;

    typedef struct packed {
        logic i_ack, d_ack, ri_en, rd_en, rd_we, x_sel, x_we, p_sel, p_we;
        logic [31:0] i_rdata, d_rdata, p_wdata;
        logic [29:0] x_addr;
        logic [23:0] p_addr;
        logic [21:0] ri_addr, rd_addr;
    } obs_t;

    obs_t  exp_q[$];
    string tag_q[$];
    int    total = 0, bad = 0;
    bit    done = 0;

    always #2.5 clk = ~clk;

    bus_region_router i_bus_region_router (
        .clk(clk), .rst_n(rst_n),
        .ifetch_req(ifetch_req), .ifetch_addr(ifetch_addr),
        .ifetch_ack(ifetch_ack), .ifetch_rdata(ifetch_rdata),
        .dat_req(dat_req), .dat_we(dat_we), .dat_addr(dat_addr), .dat_wdata(dat_wdata),
        .dat_ack(dat_ack), .dat_rdata(dat_rdata),
        .ram_i_en(ram_i_en), .ram_i_addr(ram_i_addr), .ram_i_ack(ram_i_ack),
        .ram_i_rdata(ram_i_rdata),
        .ram_d_en(ram_d_en), .ram_d_we(ram_d_we), .ram_d_addr(ram_d_addr),
        .ram_d_wdata(ram_d_wdata), .ram_d_ack(ram_d_ack), .ram_d_rdata(ram_d_rdata),
        .ext_sel(ext_sel), .ext_we(ext_we), .ext_addr(ext_addr), .ext_wdata(ext_wdata),
        .ext_ack(ext_ack), .ext_rdata(ext_rdata),
        .io_sel(io_sel), .io_we(io_we), .io_addr(io_addr), .io_wdata(io_wdata),
        .io_ack(io_ack), .io_rdata(io_rdata)
    );

    function automatic obs_t sample();
        obs_t o;
        o = '{i_ack: ifetch_ack, d_ack: dat_ack, ri_en: ram_i_en, rd_en: ram_d_en,
              rd_we: ram_d_we, x_sel: ext_sel, x_we: ext_we, p_sel: io_sel, p_we: io_we,
              i_rdata: ifetch_rdata, d_rdata: dat_rdata, p_wdata: io_wdata,
              x_addr: ext_addr, p_addr: io_addr, ri_addr: ram_i_addr, rd_addr: ram_d_addr};
        return o;
    endfunction

    // monitor: compares design outputs at the falling edge against queued expectations
    initial begin
        forever begin
            @(negedge clk);
            if (exp_q.size() > 0) begin
                obs_t  e, a;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                a = sample();
                total++;
                if (a !== e) begin
                    bad++;
                    $display("FAIL %s actual=%h expected=%h", t, a, e);
                end
            end
        end
    end

    task automatic step(input logic ir, input logic [31:0] ia,
                        input logic dr, input logic dw, input logic [31:0] da,
                        input logic [31:0] dwd, input logic xa, input logic pa,
                        input obs_t e, input string tag);
        @(posedge clk);
        #1;
        ifetch_req = ir; ifetch_addr = ia;
        dat_req = dr; dat_we = dw; dat_addr = da; dat_wdata = dwd;
        ext_ack = xa; io_ack = pa;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        wait (exp_q.size() == 0);
    endtask

    initial begin
        #100000;
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        obs_t e;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R6: idle after reset
        e = '0;
        step(0, 0, 0, 0, 0, 0, 0, 0, e, "R6 reset idle");

        // R1 / R9: fetch from RAM
        e = '0; e.ri_en = 1; e.ri_addr = 22'h40; e.i_ack = 1; e.i_rdata = 32'hA1A1_A1A1;
        step(1, 32'h0000_0100, 0, 0, 0, 0, 0, 0, e, "R1 ins ram");

        // R1: data write to last RAM word
        e = '0; e.rd_en = 1; e.rd_we = 1; e.rd_addr = 22'h3F_FFFF; e.d_ack = 1;
        e.d_rdata = 32'hD1D1_D1D1;
        step(0, 0, 1, 1, 32'h00FF_FFFC, 32'h5555_AAAA, 0, 0, e, "R1 dat ram top");

        // R2: data read at bottom of external range
        e = '0; e.x_sel = 1; e.x_addr = 30'h0040_0000; e.d_ack = 1; e.d_rdata = 32'hE0E0_E0E0;
        step(0, 0, 1, 0, 32'h0100_0000, 0, 1, 0, e, "R2 dat ext low");

        // R2 / R10: fetch at top of external range, no write
        e = '0; e.x_sel = 1; e.x_addr = 30'h3FBF_FFFF; e.i_ack = 1; e.i_rdata = 32'hE0E0_E0E0;
        step(1, 32'hFEFF_FFFC, 0, 0, 0, 0, 1, 0, e, "R2 ins ext high");

        // R3 / R10: data write to peripheral
        e = '0; e.p_sel = 1; e.p_we = 1; e.p_addr = 24'h00_0010; e.p_wdata = 32'h1234_5678;
        e.d_ack = 1; e.d_rdata = 32'hC0C0_C0C0;
        step(0, 0, 1, 1, 32'hFF00_0010, 32'h1234_5678, 0, 1, e, "R3 dat io write");

        // R10: instruction read from peripheral never writes
        e = '0; e.p_sel = 1; e.p_addr = 24'h00_0000; e.i_ack = 1; e.i_rdata = 32'hC0C0_C0C0;
        step(1, 32'hFF00_0000, 0, 0, 0, 0, 0, 1, e, "R10 ins io read");

        // R4: boot fetch answered with the no-op word; io_ack high but no io select
        e = '0; e.i_ack = 1; e.i_rdata = 32'h6000_0000;
        step(1, 32'hFFFF_FFFC, 0, 0, 0, 0, 0, 1, e, "R4 boot nop");

        // R5: data read of the same address goes to peripheral
        e = '0; e.p_sel = 1; e.p_addr = 24'hFF_FFFC; e.d_ack = 1; e.d_rdata = 32'hC0C0_C0C0;
        step(0, 0, 1, 0, 32'hFFFF_FFFC, 0, 0, 1, e, "R5 dat boot addr");

        // R4 / R5: both at once
        e = '0; e.i_ack = 1; e.i_rdata = 32'h6000_0000; e.p_sel = 1; e.p_addr = 24'hFF_FFFC;
        e.d_ack = 1; e.d_rdata = 32'hC0C0_C0C0;
        step(1, 32'hFFFF_FFFC, 1, 0, 32'hFFFF_FFFC, 0, 0, 1, e, "R5 boot both sides");

        // R9: different targets in the same cycle
        e = '0; e.ri_en = 1; e.ri_addr = 22'h1; e.i_ack = 1; e.i_rdata = 32'hA1A1_A1A1;
        e.x_sel = 1; e.x_addr = 30'h0080_0000; e.d_ack = 1; e.d_rdata = 32'hE0E0_E0E0;
        step(1, 32'h0000_0004, 1, 0, 32'h0200_0000, 0, 1, 0, e, "R9 parallel");

        // R7: simultaneous contention on external master
        e = '0; e.x_sel = 1; e.x_addr = 30'h00C0_0000;
        step(1, 32'h0200_0000, 1, 0, 32'h0300_0000, 0, 0, 0, e, "R7 dat wins wait");
        e = '0; e.x_sel = 1; e.x_addr = 30'h00C0_0000; e.d_ack = 1; e.d_rdata = 32'hE0E0_E0E0;
        step(1, 32'h0200_0000, 1, 0, 32'h0300_0000, 0, 1, 0, e, "R7 dat served");
        e = '0; e.x_sel = 1; e.x_addr = 30'h0080_0000; e.i_ack = 1; e.i_rdata = 32'hE0E0_E0E0;
        step(1, 32'h0200_0000, 0, 0, 0, 0, 1, 0, e, "R7 ins follows");

        // R8: instruction holds the external master against a later data request
        e = '0; e.x_sel = 1; e.x_addr = 30'h0080_0000;
        step(1, 32'h0200_0000, 0, 0, 0, 0, 0, 0, e, "R8 ins granted");
        e = '0; e.x_sel = 1; e.x_addr = 30'h0080_0000;
        step(1, 32'h0200_0000, 1, 1, 32'h0300_0000, 32'hDEAD_BEEF, 0, 0, e, "R8 ins held");
        e = '0; e.x_sel = 1; e.x_addr = 30'h0080_0000; e.i_ack = 1; e.i_rdata = 32'hE0E0_E0E0;
        step(1, 32'h0200_0000, 1, 1, 32'h0300_0000, 32'hDEAD_BEEF, 1, 0, e, "R8 ins served");
        e = '0; e.x_sel = 1; e.x_we = 1; e.x_addr = 30'h00C0_0000; e.d_ack = 1;
        e.d_rdata = 32'hE0E0_E0E0;
        step(0, 0, 1, 1, 32'h0300_0000, 32'hDEAD_BEEF, 1, 0, e, "R8 dat after release");

        // R8: data holds peripheral against instruction
        e = '0; e.p_sel = 1; e.p_addr = 24'h00_0040;
        step(0, 0, 1, 0, 32'hFF00_0040, 0, 0, 0, e, "R8 dat holds io");
        e = '0; e.p_sel = 1; e.p_addr = 24'h00_0040; e.d_ack = 1; e.d_rdata = 32'hC0C0_C0C0;
        step(1, 32'hFF00_0080, 1, 0, 32'hFF00_0040, 0, 0, 1, e, "R8 dat io served");

        // R6: idle again
        e = '0;
        step(0, 0, 0, 0, 0, 0, 1, 1, e, "R6 idle end");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule